// File: doc/BRIEF.md
# Configurable Parallel Pin-Bus Master

This block sits between an internal request/response port and a 32-lane external pin field. Each accepted request becomes one read or write cycle on the pins, and every bus phase is paced by an external clock-enable tick. Address and data share the same lanes. Static configuration inputs choose the address width (none, 4, 12 or 20 bits), the data width (8, 16, 24 or 32 bits), whether the RD/WR strobes are used, whether a write is issued as one phase or as an address phase followed by a data phase, and whether the interface clock is off, free-running or gated.

A read is always split in two: the first phase drives the address (if any) together with RD, and the second phase releases the lanes and samples the returned data on the tick that ends it. A per-lane output enable keeps every lane that the chosen combination does not use released. Combinations whose address and data lanes overlap, or a 32-bit data width combined with any address, strobe or clock, are flagged on an error output, and while the flag is up no request is accepted.

Top module: `pbus_master`

## Requirements
- R1: The data size code on `cfg_dsize` selects lanes [8*(code+1)-1:0] (0 = 8 bits, 1 = 16, 2 = 24, 3 = 32); read data returned on `resp_rdata` is `pin_i` masked to those lanes, sampled on the tick that ends the second read phase.
- R2: The address size code on `cfg_asize` places the request address as follows: 0 = no address, 1 = address bits [3:0] on lanes [27:24], 2 = bits [11:0] on lanes [27:16], 3 = bits [19:0] on lanes [27:8]; the address lanes are enabled only in the first phase of a transaction.
- R3: `cfg_err` rises one clock after an illegal setting is applied: address lanes overlapping the data lanes (24-bit data with a 12- or 20-bit address, 16-bit data with a 20-bit address, 32-bit data with any address), or 32-bit data with strobes, two-phase writes or the interface clock enabled; while it is high `req_ready` is low and no frame starts.
- R4: A read occupies exactly two tick periods: phase one has RD high (when strobes are in effect) and only the address lanes enabled, phase two has RD low and every lane released; RD and WR are never high together.
- R5: With single-phase writes, a write occupies one tick period with WR high (when strobes are in effect) and both address and data lanes driven and enabled.
- R6: With two-phase writes, phase one drives the address lanes only with WR high, and phase two drives the data lanes only with WR low.
- R7: With strobes disabled and single-phase writes, RD and WR stay low through every transaction; selecting two-phase writes forces both strobes into use regardless of the strobe-enable input.
- R8: `frame_o` is high during every phase of a transaction and low otherwise; while it is low all lanes are released and `pin_o` is zero.
- R9: `req_ready` is high only when idle with a legal setting, a second request is not taken until the current one completes, and completion gives a one-clock `resp_valid` pulse, with `resp_rdata` zero for writes and `req_ready` high again in that same clock.
- R10: Bus outputs change only on a clock edge where `tick` is high; with `tick` held low a pending request makes no progress.
- R11: With the gated interface clock, `bclk_o` rests high and goes low for one clock on each tick that starts a phase, never on the tick that returns to idle.
- R12: With the free-running interface clock, `bclk_o` goes low for one clock after every tick edge, idle or not; with the interface clock off it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bus clock-enable; one bus phase per tick |
| cfg_asize | input | 2 | Address size code (R2) |
| cfg_dsize | input | 2 | Data size code (R1) |
| cfg_strobe_en | input | 1 | Use the RD/WR strobes |
| cfg_wr_two | input | 1 | Issue writes as two phases |
| cfg_bclk_on | input | 1 | Interface clock in use |
| cfg_bclk_gated | input | 1 | Interface clock gated (1) or free-running (0) |
| cfg_err | output | 1 | Illegal size/control combination |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | PIN_W | Write data |
| resp_valid | output | 1 | One-clock completion pulse |
| resp_rdata | output | PIN_W | Read data (zero for writes) |
| pin_i | input | PIN_W | Lane input values |
| pin_o | output | PIN_W | Lane output values |
| pin_oe | output | PIN_W | Per-lane output enable |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| frame_o | output | 1 | Transaction in progress |
| bclk_o | output | 1 | Interface clock |

## Verification
A sequencer stuck in or skipping a phase shows at the pins on the very next tick: the frame stays high one period too long or drops a period early, and the strobe pattern or lane enables of the following phase no longer match the request type. A wrong lane decode shows in the first phase as address bits on the wrong lanes or an enable on a lane the size codes leave unused, and in the read response as bits outside the data width. A wrong error decode shows one clock after the setting is applied, as a ready signal that stays high or a frame that starts on an illegal setting.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_PH1,
    ST_PH2
  } seq_st_t;

  typedef enum logic [2:0] {
    PK_IDLE,
    PK_RD_ADDR,
    PK_RD_DATA,
    PK_WR_ONE,
    PK_WR_ADDR,
    PK_WR_DATA
  } phase_t;

endpackage

// File: rtl/pbus_lanes.sv
module pbus_lanes #(
  parameter int PIN_W    = 32,
  parameter int LANE_W   = 8,
  parameter int ADDR_TOP = 27,
  parameter int AW_S     = 4,
  parameter int AW_M     = 12,
  parameter int AW_L     = 20,
  localparam int SH_W    = $clog2(PIN_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       asize,
  input  logic [1:0]       dsize,
  input  logic             strobe_en,
  input  logic             wr_two,
  input  logic             clk_on,
  output logic [PIN_W-1:0] addr_mask,
  output logic [PIN_W-1:0] data_mask,
  output logic [SH_W-1:0]  addr_lsb,
  output logic             cfg_err
);

  localparam logic [PIN_W-1:0] ONES = '1;

  int   aw;
  int   db;
  int   sh;
  logic bad;

  always_comb begin
    case (asize)
      2'd1:    aw = AW_S;
      2'd2:    aw = AW_M;
      2'd3:    aw = AW_L;
      default: aw = 0;
    endcase
    db = LANE_W * (int'(dsize) + 1);
    sh = ADDR_TOP + 1 - aw;
    addr_lsb  = SH_W'(sh);
    addr_mask = (aw == 0) ? '0 : ((ONES >> (PIN_W - aw)) << sh);
    data_mask = ONES >> (PIN_W - db);
    bad = 1'b0;
    if (aw != 0 && sh < db) bad = 1'b1;
    if (db == PIN_W && (aw != 0 || strobe_en || wr_two || clk_on)) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad;
  end

  // R2
  lane_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable({asize, dsize, strobe_en, wr_two, clk_on}) && !cfg_err)
      |-> ((addr_mask & data_mask) == '0));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_err,
  input  logic              wr_two,
  input  logic [PIN_W-1:0]  data_mask,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PIN_W-1:0]  req_wdata,
  input  logic [PIN_W-1:0]  pin_i,
  output logic              resp_valid,
  output logic [PIN_W-1:0]  resp_rdata,
  output logic              ph_load,
  output phase_t            ph_next,
  output logic [ADDR_W-1:0] op_addr,
  output logic [PIN_W-1:0]  op_wdata
);

  seq_st_t st;
  logic    op_wr;
  logic    op_two;
  logic    done;

  assign req_ready = (st == ST_IDLE) && !cfg_err;

  always_comb begin
    ph_load = 1'b0;
    ph_next = PK_IDLE;
    done    = 1'b0;
    if (tick) begin
      case (st)
        ST_PEND: begin
          ph_load = 1'b1;
          if (!op_wr)      ph_next = PK_RD_ADDR;
          else if (op_two) ph_next = PK_WR_ADDR;
          else             ph_next = PK_WR_ONE;
        end
        ST_PH1: begin
          ph_load = 1'b1;
          if (!op_wr)      ph_next = PK_RD_DATA;
          else if (op_two) ph_next = PK_WR_DATA;
          else             done = 1'b1;
        end
        ST_PH2: begin
          ph_load = 1'b1;
          done    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      op_wr      <= 1'b0;
      op_two     <= 1'b0;
      op_addr    <= '0;
      op_wdata   <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= done;
      if (done) resp_rdata <= op_wr ? '0 : (pin_i & data_mask);
      case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          st       <= ST_PEND;
          op_wr    <= req_write;
          op_two   <= wr_two;
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
        end
        ST_PEND: if (tick) st <= ST_PH1;
        ST_PH1:  if (tick) st <= done ? ST_IDLE : ST_PH2;
        ST_PH2:  if (tick) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

endmodule

// File: rtl/pbus_drive.sv
module pbus_drive
  import pbus_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 20,
  localparam int SH_W  = $clog2(PIN_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ph_load,
  input  phase_t            ph_next,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [PIN_W-1:0]  op_wdata,
  input  logic [PIN_W-1:0]  addr_mask,
  input  logic [PIN_W-1:0]  data_mask,
  input  logic [SH_W-1:0]   addr_lsb,
  input  logic              strobe_on,
  input  logic              clk_on,
  input  logic              clk_gated,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              rd_o,
  output logic              wr_o,
  output logic              frame_o,
  output logic              bclk_o
);

  logic [PIN_W-1:0] apins;
  logic [PIN_W-1:0] dpins;

  assign apins = (PIN_W'(op_addr) << addr_lsb) & addr_mask;
  assign dpins = op_wdata & data_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o   <= '0;
      pin_oe  <= '0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      frame_o <= 1'b0;
    end else if (ph_load) begin
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
      frame_o <= 1'b1;
      pin_o   <= '0;
      pin_oe  <= '0;
      case (ph_next)
        PK_RD_ADDR: begin
          rd_o   <= strobe_on;
          pin_o  <= apins;
          pin_oe <= addr_mask;
        end
        PK_RD_DATA: ;
        PK_WR_ONE: begin
          wr_o   <= strobe_on;
          pin_o  <= apins | dpins;
          pin_oe <= addr_mask | data_mask;
        end
        PK_WR_ADDR: begin
          wr_o   <= strobe_on;
          pin_o  <= apins;
          pin_oe <= addr_mask;
        end
        PK_WR_DATA: begin
          pin_o  <= dpins;
          pin_oe <= data_mask;
        end
        default: frame_o <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            bclk_o <= 1'b1;
    else if (!clk_on)   bclk_o <= 1'b1;
    else if (clk_gated) bclk_o <= !(ph_load && ph_next != PK_IDLE);
    else                bclk_o <= !tick;
  end

  // R10
  tick_pace_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(frame_o) && $stable(pin_oe) && $stable(pin_o)
                      && $stable(rd_o) && $stable(wr_o)));

  // R8
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> frame_o);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));

  // R11
  gated_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_on && clk_gated && $past(clk_on) && $past(clk_gated) && !frame_o) |-> bclk_o);

endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int PIN_W    = 32,
  parameter int ADDR_W   = 20,
  parameter int LANE_W   = 8,
  parameter int ADDR_TOP = 27,
  parameter int AW_S     = 4,
  parameter int AW_M     = 12,
  parameter int AW_L     = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        cfg_asize,
  input  logic [1:0]        cfg_dsize,
  input  logic              cfg_strobe_en,
  input  logic              cfg_wr_two,
  input  logic              cfg_bclk_on,
  input  logic              cfg_bclk_gated,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PIN_W-1:0]  req_wdata,
  output logic              resp_valid,
  output logic [PIN_W-1:0]  resp_rdata,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  pin_o,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              rd_o,
  output logic              wr_o,
  output logic              frame_o,
  output logic              bclk_o
);

  localparam int SH_W = $clog2(PIN_W) + 1;

  logic [PIN_W-1:0]  addr_mask;
  logic [PIN_W-1:0]  data_mask;
  logic [SH_W-1:0]   addr_lsb;
  logic              ph_load;
  phase_t            ph_next;
  logic [ADDR_W-1:0] op_addr;
  logic [PIN_W-1:0]  op_wdata;

  pbus_lanes #(
    .PIN_W(PIN_W), .LANE_W(LANE_W), .ADDR_TOP(ADDR_TOP),
    .AW_S(AW_S), .AW_M(AW_M), .AW_L(AW_L)
  ) u_lanes (
    .clk(clk), .rst(rst),
    .asize(cfg_asize), .dsize(cfg_dsize),
    .strobe_en(cfg_strobe_en), .wr_two(cfg_wr_two), .clk_on(cfg_bclk_on),
    .addr_mask(addr_mask), .data_mask(data_mask), .addr_lsb(addr_lsb),
    .cfg_err(cfg_err)
  );

  pbus_seq #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_err(cfg_err), .wr_two(cfg_wr_two), .data_mask(data_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .pin_i(pin_i),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .ph_load(ph_load), .ph_next(ph_next),
    .op_addr(op_addr), .op_wdata(op_wdata)
  );

  pbus_drive #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_drive (
    .clk(clk), .rst(rst), .tick(tick),
    .ph_load(ph_load), .ph_next(ph_next),
    .op_addr(op_addr), .op_wdata(op_wdata),
    .addr_mask(addr_mask), .data_mask(data_mask), .addr_lsb(addr_lsb),
    .strobe_on(cfg_strobe_en | cfg_wr_two),
    .clk_on(cfg_bclk_on), .clk_gated(cfg_bclk_gated),
    .pin_o(pin_o), .pin_oe(pin_oe), .rd_o(rd_o), .wr_o(wr_o),
    .frame_o(frame_o), .bclk_o(bclk_o)
  );

  // R1
  rdata_width_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && $stable(cfg_dsize)) |-> ((resp_rdata & ~data_mask) == '0));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_o |-> (pin_oe == '0 && pin_o == '0));

  // R2
  lane_use_chk: assert property (@(posedge clk) disable iff (rst)
    $stable({cfg_asize, cfg_dsize}) |-> ((pin_oe & ~(addr_mask | data_mask)) == '0));

endmodule

// File: tb/tb_pbus_master.sv
module tb_pbus_master;

  localparam int DIV = 3;
  localparam logic [31:0] PIN_IN = 32'hC3A5_5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  cfg_asize = 2'd1;
  logic [1:0]  cfg_dsize = 2'd1;
  logic        cfg_strobe_en = 1'b1;
  logic        cfg_wr_two = 1'b0;
  logic        cfg_bclk_on = 1'b1;
  logic        cfg_bclk_gated = 1'b1;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic [31:0] pin_i = PIN_IN;
  logic [31:0] pin_o, pin_oe;
  logic        rd_o, wr_o, frame_o, bclk_o;

  pbus_master dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_asize(cfg_asize), .cfg_dsize(cfg_dsize), .cfg_strobe_en(cfg_strobe_en),
    .cfg_wr_two(cfg_wr_two), .cfg_bclk_on(cfg_bclk_on), .cfg_bclk_gated(cfg_bclk_gated),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .rd_o(rd_o), .wr_o(wr_o),
    .frame_o(frame_o), .bclk_o(bclk_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_low = 0;
  int n_frame = 0;
  int div_cnt = 0;
  logic tick_en = 1'b1;

  logic [31:0] lg_pin [64];
  logic [31:0] lg_oe [64];
  logic        lg_rd [64];
  logic        lg_wr [64];
  logic        lg_fr [64];
  int          lg_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (bclk_o == 1'b0) n_low++;
    if (frame_o) n_frame++;
    if (tick && lg_n < 64) begin
      lg_pin[lg_n] = pin_o;
      lg_oe[lg_n]  = pin_oe;
      lg_rd[lg_n]  = rd_o;
      lg_wr[lg_n]  = wr_o;
      lg_fr[lg_n]  = frame_o;
      lg_n++;
    end
    if (tick_en) begin
      div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
      tick = (div_cnt == 0);
    end else begin
      tick = 1'b0;
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired act=%0d exp=<100000", cyc);
        finish_run();
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] amask(input logic [1:0] a);
    case (a)
      2'd1: return 32'h0F00_0000;
      2'd2: return 32'h0FFF_0000;
      2'd3: return 32'h0FFF_FF00;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] apos(input logic [1:0] a, input logic [19:0] ad);
    case (a)
      2'd1: return {4'h0, ad[3:0], 24'h0};
      2'd2: return {4'h0, ad[11:0], 16'h0};
      2'd3: return {4'h0, ad[19:0], 8'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] dmask(input logic [1:0] d);
    case (d)
      2'd0: return 32'h0000_00FF;
      2'd1: return 32'h0000_FFFF;
      2'd2: return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int first_frame();
    for (int i = 0; i < lg_n; i++) if (lg_fr[i]) return i;
    return 60;
  endfunction

  task automatic set_cfg(input logic [1:0] a, input logic [1:0] d, input logic s,
                         input logic w, input logic on, input logic g);
    @(negedge clk);
    cfg_asize = a; cfg_dsize = d; cfg_strobe_en = s;
    cfg_wr_two = w; cfg_bclk_on = on; cfg_bclk_gated = g;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_req(input logic wr, input logic [19:0] ad, input logic [31:0] wd,
                        output logic [31:0] rdata, output int lows);
    int l0;
    int guard;
    @(negedge clk);
    lg_n = 0;
    l0 = n_low;
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!resp_valid && guard < 200) begin @(negedge clk); guard++; end
    chk("R9 response pulse seen", {31'h0, resp_valid}, 32'h1);
    chk("R9 ready back with response", {31'h0, req_ready}, 32'h1);
    rdata = resp_rdata;
    lows = n_low - l0;
    @(negedge clk);
    chk("R9 response lasts one clock", {31'h0, resp_valid}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R8 frame low after reset", {31'h0, frame_o}, 32'h0);
    chk("R8 lanes released after reset", pin_oe, 32'h0);
    chk("R4 strobes low after reset", {30'h0, rd_o, wr_o}, 32'h0);
    chk("R11 gated clock rests high", {31'h0, bclk_o}, 32'h1);
    chk("R9 ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R3 no error on legal setting", {31'h0, cfg_err}, 32'h0);
  endtask

  task automatic t_read(input logic [1:0] a, input logic [1:0] d, input logic s,
                        input logic [19:0] ad, input string tag);
    logic [31:0] rd;
    int lows;
    int k;
    logic stb;
    set_cfg(a, d, s, 1'b0, (d != 2'd3), 1'b1);
    stb = s;
    do_req(1'b0, ad, 32'h0, rd, lows);
    k = first_frame();
    chk({tag, " R4 phase1 frame"}, {31'h0, lg_fr[k]}, 32'h1);
    chk({tag, " R7 phase1 rd"}, {31'h0, lg_rd[k]}, {31'h0, stb});
    chk({tag, " R2 phase1 lanes"}, lg_oe[k], amask(a));
    chk({tag, " R2 phase1 address"}, lg_pin[k], apos(a, ad));
    chk({tag, " R4 phase2 frame/rd/wr"}, {29'h0, lg_fr[k+1], lg_rd[k+1], lg_wr[k+1]}, 32'h4);
    chk({tag, " R4 phase2 released"}, lg_oe[k+1], 32'h0);
    chk({tag, " R8 idle after read"}, {31'h0, lg_fr[k+2]}, 32'h0);
    chk({tag, " R1 read data"}, rd, PIN_IN & dmask(d));
    if (d != 2'd3) chk({tag, " R11 gated pulses per read"}, lows, 32'd2);
  endtask

  task automatic t_write(input logic [1:0] a, input logic [1:0] d, input logic s,
                         input logic w, input logic [19:0] ad, input logic [31:0] wd,
                         input string tag);
    logic [31:0] rd;
    int lows;
    int k;
    set_cfg(a, d, s, w, (d != 2'd3), 1'b1);
    do_req(1'b1, ad, wd, rd, lows);
    k = first_frame();
    chk({tag, " R9 write returns zero"}, rd, 32'h0);
    chk({tag, " R4 no rd on write"}, {31'h0, lg_rd[k]}, 32'h0);
    if (!w) begin
      chk({tag, " R5 wr strobe"}, {31'h0, lg_wr[k]}, {31'h0, s});
      chk({tag, " R5 lanes"}, lg_oe[k], amask(a) | dmask(d));
      chk({tag, " R5 value"}, lg_pin[k], apos(a, ad) | (wd & dmask(d)));
      chk({tag, " R8 idle after write"}, {31'h0, lg_fr[k+1]}, 32'h0);
      if (d != 2'd3) chk({tag, " R11 gated pulses"}, lows, 32'd1);
    end else begin
      chk({tag, " R6 R7 phase1 wr forced"}, {31'h0, lg_wr[k]}, 32'h1);
      chk({tag, " R6 phase1 lanes"}, lg_oe[k], amask(a));
      chk({tag, " R6 phase1 address"}, lg_pin[k], apos(a, ad));
      chk({tag, " R6 phase2 frame/wr"}, {30'h0, lg_fr[k+1], lg_wr[k+1]}, 32'h2);
      chk({tag, " R6 phase2 lanes"}, lg_oe[k+1], dmask(d));
      chk({tag, " R6 phase2 data"}, lg_pin[k+1], wd & dmask(d));
      chk({tag, " R8 idle after write"}, {31'h0, lg_fr[k+2]}, 32'h0);
      chk({tag, " R11 gated pulses"}, lows, 32'd2);
    end
  endtask

  task automatic t_forced_read();
    logic [31:0] rd;
    int lows;
    int k;
    set_cfg(2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    do_req(1'b0, 20'h00ABC, 32'h0, rd, lows);
    k = first_frame();
    chk("R7 two-phase forces rd", {31'h0, lg_rd[k]}, 32'h1);
    chk("R1 16-bit read data", rd, PIN_IN & 32'h0000_FFFF);
  endtask

  task automatic t_illegal(input logic [1:0] a, input logic [1:0] d, input logic s,
                           input string tag);
    int f0;
    set_cfg(a, d, s, 1'b0, 1'b0, 1'b1);
    chk({tag, " R3 error raised"}, {31'h0, cfg_err}, 32'h1);
    chk({tag, " R3 ready low"}, {31'h0, req_ready}, 32'h0);
    f0 = n_frame;
    req_valid = 1'b1; req_write = 1'b0;
    repeat (30) @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R3 no frame on illegal setting"}, n_frame - f0, 32'd0);
    set_cfg(2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk({tag, " R3 error clears"}, {31'h0, cfg_err}, 32'h0);
  endtask

  task automatic t_tick_hold();
    int guard;
    set_cfg(2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    tick_en = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h5;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 no frame without tick", {31'h0, frame_o}, 32'h0);
    chk("R10 not ready while pending", {31'h0, req_ready}, 32'h0);
    tick_en = 1'b1;
    guard = 0;
    while (!resp_valid && guard < 100) begin @(negedge clk); guard++; end
    chk("R10 completes once ticks resume", {31'h0, resp_valid}, 32'h1);
    chk("R1 8-bit read data", resp_rdata, PIN_IN & 32'h0000_00FF);
    @(negedge clk);
  endtask

  task automatic t_clock_modes();
    int l0;
    set_cfg(2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    l0 = n_low;
    repeat (30) @(negedge clk);
    chk("R12 free-running low clocks in 30", n_low - l0, 32'd10);
    set_cfg(2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    l0 = n_low;
    repeat (30) @(negedge clk);
    chk("R11 gated idle no pulses", n_low - l0, 32'd0);
    set_cfg(2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    l0 = n_low;
    repeat (30) @(negedge clk);
    chk("R12 clock off stays high", n_low - l0, 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_read(2'd1, 2'd2, 1'b1, 20'h0000A, "rd a4 d24");
    t_read(2'd2, 2'd1, 1'b1, 20'h00F5E, "rd a12 d16");
    t_read(2'd3, 2'd0, 1'b1, 20'hB6D49, "rd a20 d8");
    t_read(2'd0, 2'd3, 1'b0, 20'h00000, "rd none d32");
    t_read(2'd0, 2'd0, 1'b0, 20'h00000, "rd none d8 nostrobe");
    t_write(2'd1, 2'd1, 1'b1, 1'b0, 20'h00003, 32'h1234_9876, "wr1 a4 d16");
    t_write(2'd0, 2'd3, 1'b0, 1'b0, 20'h00000, 32'hDEAD_BEEF, "wr1 none d32");
    t_write(2'd3, 2'd0, 1'b0, 1'b0, 20'h7A5C3, 32'hFFFF_FF5A, "wr1 a20 nostrobe");
    t_write(2'd2, 2'd1, 1'b0, 1'b1, 20'h00C4D, 32'h5555_AAAA, "wr2 a12 d16");
    t_write(2'd0, 2'd2, 1'b0, 1'b1, 20'h00000, 32'h0F1E_2D3C, "wr2 none d24");
    t_forced_read();
    t_illegal(2'd2, 2'd2, 1'b1, "a12 d24");
    t_illegal(2'd3, 2'd1, 1'b1, "a20 d16");
    t_illegal(2'd0, 2'd3, 1'b1, "d32 strobes");
    t_tick_hold();
    t_clock_modes();
    finish_run();
  end

endmodule